// File: doc/BRIEF.md
# Byte-Wide Memory SEC-DED Adapter

This block sits between a 32-bit internal read/write port and an external memory that is only eight bits wide. Each 32-bit word is protected by a 7-bit check code that corrects any single flipped bit and detects any two flipped bits. The check bytes live in a reserved region at the top of the same memory device, so no separate check-bit device is needed. A word read becomes four data-byte accesses and one check-byte access, after which the word is corrected or flagged. A word write computes the code and stores it after the four data bytes.

Byte and halfword writes can be done as read-modify-write: the adapter reads and corrects the stored word, merges in the new bytes, re-encodes and writes back the whole word with its check byte. Three strap inputs, sampled during reset, pick the width and whether protection is present, and flag an illegal setting. A diagnostic write bypass stores a software-supplied test check value in place of the computed code. A diagnostic read bypass captures the raw check bits of each read into that same test register. Corrected reads are counted in a saturating counter.

Top module: `byteEccAdapter`

## Requirements
- R1: Data bit i of the word uses H-matrix column c_i, where c_0..c_31 are the 7-bit values with exactly three ones taken in ascending numeric order; check bit k is the XOR of the data bits whose column has bit k set. The check byte holds the code in bits [6:0] with bit 7 written 0. A full-word write to word n issues, in this order, byte addresses 4n, 4n+1, 4n+2, 4n+3 (lanes 0..3, lane 0 = data bits [7:0]) and then the check byte at base+n.
- R2: The check region base is floor(MEM_BYTES*4/5) when cfgPack3 is 0 and MEM_BYTES*3/4 when cfgPack3 is 1 (1638 and 1536 for 2048 bytes).
- R3: A read of an intact word returns the stored data with cpuCorr and cpuErr both 0 on the single cycle where cpuDone is 1.
- R4: A read whose stored 39-bit codeword has exactly one flipped bit (data or check) returns the original data with cpuCorr 1 and cpuErr 0.
- R5: A read whose stored codeword has exactly two flipped bits returns cpuErr 1 and cpuCorr 0.
- R6: corrCount increments once per corrected access and holds at its all-ones value.
- R7: With cfgChkEn 0, reads return the raw stored bytes, cpuCorr and cpuErr stay 0 and corrCount does not change.
- R8: strapPins are sampled while rst is 1. Bit 1 is reported on strapWide; pattern x11 sets strapBad and disables protection; otherwise bit 2 = 1 enables protection. Without protection a read makes only the four data accesses and no check-byte access.
- R9: With cfgRmw 1 and protection on, a write with cpuBe not all ones reads and corrects the word, replaces the enabled lanes, and writes all four data bytes plus the new check byte; if the read is uncorrectable the write is abandoned with cpuErr 1 and memory is left unchanged.
- R10: With cfgRmw 0, a write with cpuBe not all ones writes only the enabled lanes and leaves the check byte and other lanes unchanged.
- R11: With cfgWrBypass 1, the check byte written is {0, tcbOut} instead of the computed code.
- R12: A tcbLoad pulse loads tcbIn into the test check register shown on tcbOut; with cfgRdBypass 1 and protection on, each read loads the raw check bits [6:0] just fetched into it.
- R13: Once memReq is raised it stays raised with memAddr and memWe unchanged until memRdy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strapPins | input | 3 | Mode straps, sampled during reset |
| cfgPack3 | input | 1 | Selects the larger check region (3:1 packing) |
| cfgChkEn | input | 1 | Enables correction and error reporting |
| cfgRmw | input | 1 | Enables read-modify-write for partial writes |
| cfgWrBypass | input | 1 | Writes test check value instead of computed code |
| cfgRdBypass | input | 1 | Captures raw check bits of reads |
| tcbLoad | input | 1 | Loads tcbIn into the test check register |
| tcbIn | input | 7 | Value for the test check register |
| tcbOut | output | 7 | Test check register |
| corrCount | output | CNT_W | Saturating corrected-error count |
| strapWide | output | 1 | Latched width strap |
| strapBad | output | 1 | Illegal strap setting seen |
| cpuReq | input | 1 | Start an access (one cycle, only when idle) |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | WA_W | Word index |
| cpuBe | input | 4 | Byte lane enables for writes |
| cpuWdata | input | 32 | Write data |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read data, valid with cpuDone |
| cpuCorr | output | 1 | Corrected error, valid with cpuDone |
| cpuErr | output | 1 | Uncorrectable error, valid with cpuDone |
| memReq | output | 1 | Byte access request |
| memWe | output | 1 | Byte access is a write |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 8 | Byte write data |
| memRdata | input | 8 | Byte read data, valid with memRdy |
| memRdy | input | 1 | Byte access accepted this cycle |

## Verification
Every access ends in a one-cycle cpuDone pulse; with a memory that is always ready a read completes seven cycles after cpuReq is taken, but the bench model inserts random ready stalls, so the bench waits on cpuDone and samples read data and flags at the falling edge inside that pulse rather than at a fixed count. Memory contents written by a write are read from the bench's byte model after cpuDone, once the last accepted byte has been stored. The test register is checked one full cycle after a tcbLoad pulse or after the read's cpuDone, and the access order and request hold are checked by a monitor at every rising edge.

// File: rtl/byteEccPkg.sv
package byteEccPkg;
  localparam int DW        = 32;
  localparam int CW        = 7;
  localparam int LANES     = DW / 8;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int SEQ_W     = LANE_BITS + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_EVAL, S_MERGE, S_WRITE, S_DONE
  } seqState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             start;
    logic             capture;
    logic             evalDone;
    logic             merge;
    logic [SEQ_W-1:0] lane;
  } dpStrobe_t;

  // Odd-weight (three ones) columns in ascending order, one per data bit
  function automatic logic [DW-1:0][CW-1:0] buildColumns();
    logic [DW-1:0][CW-1:0] cols;
    int k;
    cols = '0;
    k = 0;
    for (int v = 1; v < (1 << CW); v++) begin
      if ($countones(CW'(v)) == 3 && k < DW) begin
        cols[k] = CW'(v);
        k++;
      end
    end
    return cols;
  endfunction

  localparam logic [DW-1:0][CW-1:0] H_COLS = buildColumns();

  function automatic logic [CW-1:0] encodeWord(input logic [DW-1:0] d);
    logic [CW-1:0] p;
    p = '0;
    for (int i = 0; i < DW; i++) begin
      if (d[i]) p ^= H_COLS[i];
    end
    return p;
  endfunction
endpackage

// File: rtl/byteEccDatapath.sv
module byteEccDatapath
  import byteEccPkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int CNT_W     = 4,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int WA_W     = ADDR_W - LANE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         st,
  input  logic [WA_W-1:0]   cpuAddr,
  input  logic [LANES-1:0]  cpuBe,
  input  logic [DW-1:0]     cpuWdata,
  input  logic [7:0]        memRdata,
  input  logic              cfgPack3,
  input  logic              cfgWrBypass,
  input  logic              cfgRdBypass,
  input  logic              tcbLoad,
  input  logic [CW-1:0]     tcbIn,
  input  logic              chkActive,
  input  logic              protOn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [DW-1:0]     cpuRdata,
  output logic              synCorr,
  output logic              synBad,
  output logic [LANES-1:0]  beOut,
  output logic [CW-1:0]     tcbOut,
  output logic [CNT_W-1:0]  corrCount
);
  localparam int BASE4 = (MEM_BYTES * 4) / 5;
  localparam int BASE3 = (MEM_BYTES * 3) / 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WA_W-1:0]  addrQ;
  logic [LANES-1:0] beQ;
  logic [DW-1:0]    wdQ, bufQ, rdataQ;
  logic [CW-1:0]    chkQ, tcbQ;
  logic [CNT_W-1:0] cntQ;

  logic [CW-1:0]    encNow, syn;
  logic [DW-1:0]    hit, fixData, outData, merged;
  logic [ADDR_W-1:0] chkBase;
  logic             isChkLane;

  always_comb begin
    encNow = encodeWord(bufQ);
    syn    = encNow ^ chkQ;
    for (int j = 0; j < DW; j++) hit[j] = (syn == H_COLS[j]);
    fixData = bufQ ^ hit;
    synCorr = (^syn) & ((|hit) | ($countones(syn) == 1));
    synBad  = (syn != '0) & ~synCorr;
    outData = chkActive ? fixData : bufQ;
  end

  for (genvar g = 0; g < LANES; g++) begin : gMerge
    assign merged[g*8 +: 8] = beQ[g] ? wdQ[g*8 +: 8] : outData[g*8 +: 8];
  end

  assign isChkLane = (st.lane == SEQ_W'(LANES));
  assign chkBase   = cfgPack3 ? ADDR_W'(BASE3) : ADDR_W'(BASE4);
  assign memAddr   = isChkLane ? chkBase + ADDR_W'(addrQ) : {addrQ, st.lane[LANE_BITS-1:0]};
  assign memWdata  = isChkLane ? {{(8-CW){1'b0}}, (cfgWrBypass ? tcbQ : encNow)}
                               : bufQ[st.lane[LANE_BITS-1:0]*8 +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0; beQ <= '0; wdQ <= '0; bufQ <= '0;
      chkQ <= '0; rdataQ <= '0; tcbQ <= '0; cntQ <= '0;
    end else begin
      if (st.start) begin
        addrQ <= cpuAddr;
        beQ   <= cpuBe;
        wdQ   <= cpuWdata;
      end
      if (st.capture) begin
        if (isChkLane) chkQ <= memRdata[CW-1:0];
        else bufQ[st.lane[LANE_BITS-1:0]*8 +: 8] <= memRdata;
      end
      if (st.merge) bufQ <= merged;
      if (st.evalDone) begin
        rdataQ <= outData;
        if (chkActive && synCorr && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
      end
      if (st.evalDone && cfgRdBypass && protOn) tcbQ <= chkQ;
      else if (tcbLoad) tcbQ <= tcbIn;
    end
  end

  assign cpuRdata  = rdataQ;
  assign beOut     = beQ;
  assign tcbOut    = tcbQ;
  assign corrCount = cntQ;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    corrCount == CNT_MAX |=> corrCount == CNT_MAX); // R6
endmodule

// File: rtl/byteEccCtrl.sv
module byteEccCtrl
  import byteEccPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic [LANES-1:0] cpuBe,
  input  logic             cfgRmw,
  input  logic             protOn,
  input  logic             chkActive,
  input  logic             synCorr,
  input  logic             synBad,
  input  logic [LANES-1:0] beQ,
  input  logic             memRdy,
  output dpStrobe_t        st,
  output logic             memReq,
  output logic             memWe,
  output logic             cpuDone,
  output logic             cpuCorr,
  output logic             cpuErr
);
  localparam logic [SEQ_W-1:0] CHK_LANE = SEQ_W'(LANES);

  seqState_e        state;
  logic [SEQ_W-1:0] lane;
  logic             fullQ, rmwQ, errQ, corrQ;
  logic             lastRd, wrUse, rmwStart;

  assign lastRd   = (lane == CHK_LANE) || (lane == CHK_LANE - 1'b1 && !protOn);
  assign wrUse    = (lane == CHK_LANE) ? (protOn && (fullQ || rmwQ))
                                       : (fullQ || rmwQ || beQ[lane[LANE_BITS-1:0]]);
  assign rmwStart = cpuWe && !(&cpuBe) && cfgRmw && protOn;

  always_comb begin
    st      = '0;
    st.lane = lane;
    memReq  = 1'b0;
    memWe   = 1'b0;
    unique case (state)
      S_IDLE:  st.start = cpuReq;
      S_READ:  begin memReq = 1'b1; st.capture = memRdy; end
      S_EVAL:  st.evalDone = 1'b1;
      S_MERGE: st.merge = 1'b1;
      S_WRITE: begin memReq = wrUse; memWe = wrUse; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; lane <= '0;
      fullQ <= 1'b0; rmwQ <= 1'b0; errQ <= 1'b0; corrQ <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (cpuReq) begin
          fullQ <= &cpuBe;
          rmwQ  <= rmwStart;
          errQ  <= 1'b0;
          corrQ <= 1'b0;
          lane  <= '0;
          state <= (!cpuWe || rmwStart) ? S_READ : S_MERGE;
        end
        S_READ: if (memRdy) begin
          if (lastRd) state <= S_EVAL;
          else lane <= lane + 1'b1;
        end
        S_EVAL: begin
          errQ  <= chkActive && synBad;
          corrQ <= chkActive && synCorr;
          state <= (rmwQ && !(chkActive && synBad)) ? S_MERGE : S_DONE;
        end
        S_MERGE: begin lane <= '0; state <= S_WRITE; end
        S_WRITE: if (!wrUse || memRdy) begin
          if (lane == CHK_LANE) state <= S_DONE;
          else lane <= lane + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cpuDone = (state == S_DONE);
  assign cpuCorr = cpuDone && corrQ;
  assign cpuErr  = cpuDone && errQ;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    memReq && !memRdy |=> memReq && $stable(lane) && $stable(memWe)); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpuDone |=> !cpuDone); // R3
  AST_ERR_CORR_EXCL: assert property (@(posedge clk) disable iff (rst)
    cpuDone |-> !(cpuErr && cpuCorr)); // R5
  AST_NO_CHECK_LANE: assert property (@(posedge clk) disable iff (rst)
    memReq && !protOn |-> lane != CHK_LANE); // R8
endmodule

// File: rtl/byteEccAdapter.sv
module byteEccAdapter
  import byteEccPkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int CNT_W     = 4,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int WA_W     = ADDR_W - LANE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        strapPins,
  input  logic              cfgPack3,
  input  logic              cfgChkEn,
  input  logic              cfgRmw,
  input  logic              cfgWrBypass,
  input  logic              cfgRdBypass,
  input  logic              tcbLoad,
  input  logic [CW-1:0]     tcbIn,
  output logic [CW-1:0]     tcbOut,
  output logic [CNT_W-1:0]  corrCount,
  output logic              strapWide,
  output logic              strapBad,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [WA_W-1:0]   cpuAddr,
  input  logic [LANES-1:0]  cpuBe,
  input  logic [DW-1:0]     cpuWdata,
  output logic              cpuDone,
  output logic [DW-1:0]     cpuRdata,
  output logic              cpuCorr,
  output logic              cpuErr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic              memRdy
);
  logic [2:0]       strapQ;
  logic             protOn, chkActive, synCorr, synBad;
  logic [LANES-1:0] beQ;
  dpStrobe_t        st;

  always_ff @(posedge clk) begin
    if (rst) strapQ <= strapPins;
  end

  assign strapWide = strapQ[1];
  assign strapBad  = strapQ[1] & strapQ[0];
  assign protOn    = strapQ[2] & ~strapBad;
  assign chkActive = protOn & cfgChkEn;

  byteEccCtrl uCtrl (
    .clk, .rst, .cpuReq, .cpuWe, .cpuBe, .cfgRmw, .protOn, .chkActive,
    .synCorr, .synBad, .beQ, .memRdy, .st, .memReq, .memWe,
    .cpuDone, .cpuCorr, .cpuErr
  );

  byteEccDatapath #(.MEM_BYTES(MEM_BYTES), .CNT_W(CNT_W)) uDp (
    .clk, .rst, .st, .cpuAddr, .cpuBe, .cpuWdata, .memRdata,
    .cfgPack3, .cfgWrBypass, .cfgRdBypass, .tcbLoad, .tcbIn,
    .chkActive, .protOn, .memAddr, .memWdata, .cpuRdata,
    .synCorr, .synBad, .beOut(beQ), .tcbOut, .corrCount
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    memReq && !memRdy |=> $stable(memAddr)); // R13
endmodule

// File: tb/byteEccAdapter_test.sv
module byteEccAdapter_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 2048;
  localparam int BASE4      = 1638;
  localparam int BASE3      = 1536;

  logic        clk, rst;
  logic [2:0]  strapPins;
  logic        cfgPack3, cfgChkEn, cfgRmw, cfgWrBypass, cfgRdBypass, tcbLoad;
  logic [6:0]  tcbIn, tcbOut;
  logic [3:0]  corrCount;
  logic        strapWide, strapBad;
  logic        cpuReq, cpuWe, cpuDone, cpuCorr, cpuErr;
  logic [8:0]  cpuAddr;
  logic [3:0]  cpuBe;
  logic [31:0] cpuWdata, cpuRdata;
  logic        memReq, memWe, memRdy;
  logic [10:0] memAddr;
  logic [7:0]  memWdata, memRdata;

  byteEccAdapter #(.MEM_BYTES(MEM_BYTES), .CNT_W(4)) uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Byte memory model with random ready, access log and fault injection
  logic [7:0]  mem [MEM_BYTES];
  logic        injEn;
  logic [10:0] injAddr;
  logic [7:0]  injMask;
  int          accCount = 0;
  int          holdViol = 0;
  logic [10:0] logA [16];
  logic        prevStall = 1'b0;
  logic [10:0] prevAddr  = '0;
  logic        prevWe    = 1'b0;

  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if (memReq && memRdy && memWe) mem[memAddr] <= memWdata;
    if (injEn) mem[injAddr] <= mem[injAddr] ^ injMask;
    if (memReq && memRdy) begin
      logA[accCount % 16] <= memAddr;
      accCount <= accCount + 1;
    end
    if (!rst && prevStall && (!memReq || memAddr != prevAddr || memWe != prevWe))
      holdViol <= holdViol + 1;
    prevStall <= memReq && !memRdy;
    prevAddr  <= memAddr;
    prevWe    <= memWe;
  end

  always @(negedge clk) memRdy <= ($urandom % 4) != 0;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] rRd;
  logic        rErr, rCorr;

  function automatic logic [6:0] refCode(input logic [31:0] d);
    logic [6:0] p, vv;
    int col;
    p = '0; col = 0;
    for (int v = 1; v < 128; v++) begin
      vv = 7'(v);
      if ($countones(vv) == 3) begin
        if (col < 32 && d[col]) p ^= vv;
        col++;
      end
    end
    return p;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic we, input int addr, input logic [3:0] be, input logic [31:0] wd);
    int t;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = 9'(addr); cpuBe = be; cpuWdata = wd;
    @(negedge clk);
    cpuReq = 1'b0;
    t = 0;
    while (!cpuDone && t < 500) begin @(negedge clk); t++; end
    if (!cpuDone) chk("timeout waiting for cpuDone", 0, 1);
    rRd = cpuRdata; rErr = cpuErr; rCorr = cpuCorr;
  endtask

  task automatic inject(input int a, input logic [7:0] m);
    @(negedge clk);
    injEn = 1'b1; injAddr = 11'(a); injMask = m;
    @(negedge clk);
    injEn = 1'b0;
  endtask

  task automatic flipBit(input int n, input int j, input int base);
    if (j < 32) inject(4*n + j/8, 8'(1 << (j % 8)));
    else        inject(base + n, 8'(1 << (j - 32)));
  endtask

  task automatic resetWith(input logic [2:0] s);
    strapPins = s;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    nChecks++; nFail++;
    finishRun();
  end

  initial begin
    logic [31:0] d, e;
    logic [7:0]  snap [5];
    int n, c0;
    void'($urandom(32'd20240611));
    cpuReq = 0; cpuWe = 0; cpuAddr = '0; cpuBe = '0; cpuWdata = '0;
    cfgPack3 = 0; cfgChkEn = 1; cfgRmw = 0; cfgWrBypass = 0; cfgRdBypass = 0;
    tcbLoad = 0; tcbIn = '0; injEn = 0; injAddr = '0; injMask = '0; rst = 0;
    resetWith(3'b100);

    chk("R3 reset cpuDone", cpuDone, 0);
    chk("R6 reset corrCount", corrCount, 0);
    chk("R12 reset tcbOut", tcbOut, 0);
    chk("R8 strap 100 bad/wide", {strapBad, strapWide}, 0);

    // R1/R3 random clean traffic
    for (int i = 0; i < 30; i++) begin
      n = $urandom % 384; d = $urandom;
      doOp(1, n, 4'hF, d);
      chk("R1 check byte content", mem[BASE4 + n], {1'b0, refCode(d)});
      doOp(0, n, 4'h0, 0);
      chk("R3 clean read", {rRd, rCorr, rErr}, {d, 2'b00});
    end

    // R1 access order
    n = 77; d = 32'hDEADBEEF; c0 = accCount;
    doOp(1, n, 4'hF, d);
    chk("R1 access count", accCount - c0, 5);
    for (int k = 0; k < 4; k++) chk("R1 data lane order", logA[(c0 + k) % 16], 4*n + k);
    chk("R1 check address", logA[(c0 + 4) % 16], BASE4 + n);
    chk("R2 base 4:1", mem[BASE4 + n], {1'b0, refCode(d)});

    // R7 checking disabled: raw data, no flags, counter unchanged
    cfgChkEn = 0;
    n = 12; d = 32'h0F0F1234;
    doOp(1, n, 4'hF, d);
    flipBit(n, 9, BASE4);
    doOp(0, n, 4'h0, 0);
    chk("R7 raw data no flags", {rRd, rCorr, rErr}, {d ^ 32'h200, 2'b00});
    chk("R7 counter unchanged", corrCount, 0);
    cfgChkEn = 1;

    // R4 every single-bit error
    n = 10; d = 32'hA5C31E7F;
    for (int j = 0; j < 39; j++) begin
      doOp(1, n, 4'hF, d);
      flipBit(n, j, BASE4);
      doOp(0, n, 4'h0, 0);
      chk($sformatf("R4 single bit %0d", j), {rRd, rCorr, rErr}, {d, 2'b10});
      if (j == 3) chk("R6 count after four", corrCount, 4);
    end
    chk("R6 counter saturated", corrCount, 4'hF);

    // R5 double-bit errors
    for (int i = 0; i < 20; i++) begin
      int j1, j2;
      n = 40 + i; d = $urandom;
      j1 = $urandom % 39;
      j2 = (j1 + 1 + ($urandom % 38)) % 39;
      doOp(1, n, 4'hF, d);
      flipBit(n, j1, BASE4);
      flipBit(n, j2, BASE4);
      doOp(0, n, 4'h0, 0);
      chk($sformatf("R5 double %0d/%0d", j1, j2), {rCorr, rErr}, 2'b01);
    end

    // R2 3:1 packing region
    cfgPack3 = 1;
    n = 7; d = 32'h13579BDF;
    doOp(1, n, 4'hF, d);
    chk("R2 base 3:1", mem[BASE3 + n], {1'b0, refCode(d)});
    doOp(0, n, 4'h0, 0);
    chk("R2 read 3:1", {rRd, rCorr, rErr}, {d, 2'b00});
    cfgPack3 = 0;

    // R9 read-modify-write with a corrected lane
    cfgRmw = 1;
    n = 20; d = 32'h11223344; e = 32'h1122CC44;
    doOp(1, n, 4'hF, d);
    flipBit(n, 3, BASE4);
    doOp(1, n, 4'b0010, 32'hAABBCCDD);
    chk("R9 rmw corrected flag", {rCorr, rErr}, 2'b10);
    for (int k = 0; k < 4; k++) chk("R9 rmw data byte", mem[4*n + k], e[8*k +: 8]);
    chk("R9 rmw check byte", mem[BASE4 + n], {1'b0, refCode(e)});
    doOp(0, n, 4'h0, 0);
    chk("R9 rmw readback", {rRd, rCorr, rErr}, {e, 2'b00});
    // R9 abort on uncorrectable
    flipBit(n, 0, BASE4);
    flipBit(n, 1, BASE4);
    for (int k = 0; k < 4; k++) snap[k] = mem[4*n + k];
    snap[4] = mem[BASE4 + n];
    doOp(1, n, 4'b0100, 32'h55555555);
    chk("R9 rmw abort err", rErr, 1);
    for (int k = 0; k < 4; k++) chk("R9 abort lane kept", mem[4*n + k], snap[k]);
    chk("R9 abort check kept", mem[BASE4 + n], snap[4]);
    cfgRmw = 0;

    // R10 partial write without rmw
    n = 30; d = 32'h01020304;
    doOp(1, n, 4'hF, d);
    snap[4] = mem[BASE4 + n];
    doOp(1, n, 4'b0101, 32'hF0E0D0C0);
    chk("R10 lanes", {mem[4*n+3], mem[4*n+2], mem[4*n+1], mem[4*n]}, 32'h01E003C0);
    chk("R10 check untouched", mem[BASE4 + n], snap[4]);

    // R12 test register load, R11 write bypass
    @(negedge clk); tcbLoad = 1; tcbIn = 7'h2A;
    @(negedge clk); tcbLoad = 0;
    @(negedge clk);
    chk("R12 tcbLoad", tcbOut, 7'h2A);
    cfgWrBypass = 1;
    n = 50;
    doOp(1, n, 4'hF, 32'h89ABCDEF);
    chk("R11 bypass check byte", mem[BASE4 + n], 8'h2A);
    cfgWrBypass = 0;
    // R12 read bypass captures raw check bits
    n = 51; d = 32'h76543210;
    doOp(1, n, 4'hF, d);
    cfgRdBypass = 1;
    doOp(0, n, 4'h0, 0);
    @(negedge clk);
    chk("R12 read bypass capture", tcbOut, refCode(d));
    cfgRdBypass = 0;

    chk("R13 request held during stalls", holdViol, 0);

    // R8 strap decoding
    resetWith(3'b000);
    chk("R8 strap 000 bad/wide", {strapBad, strapWide}, 0);
    n = 5; d = 32'hCAFEF00D;
    doOp(1, n, 4'hF, d);
    c0 = accCount;
    doOp(0, n, 4'h0, 0);
    chk("R8 unprotected read data", {rRd, rCorr, rErr}, {d, 2'b00});
    chk("R8 unprotected access count", accCount - c0, 4);
    resetWith(3'b011);
    chk("R8 strap 011 illegal", strapBad, 1);
    resetWith(3'b111);
    chk("R8 strap 111 illegal", strapBad, 1);
    c0 = accCount;
    doOp(0, n, 4'h0, 0);
    chk("R8 illegal strap no check access", accCount - c0, 4);
    resetWith(3'b110);
    chk("R8 strap 110 wide", {strapBad, strapWide}, 2'b01);

    finishRun();
  end
endmodule